// File: doc/BRIEF.md
# SpaceWire Character Receiver

This block turns a recovered serial bit stream into SpaceWire characters. Each bit arrives on `rx_bit` and is accepted only on a clock edge where `rx_valid` is high. The block assembles the bits into data and control characters and checks their parity. It pairs escape characters with the character that follows them to find NULLs and Time-codes. Each result it reports is a one-cycle pulse, and data values are given in parallel.

The receiver is held idle while `link_en` is low, which is the link's error-reset state. After `link_en` rises, the receiver reports nothing until the first NULL has arrived. From then on it checks parity, escape sequences and flow-control credit. Any error raises a flag and the error-reset request, and the receiver stops reporting until the link controller drops `link_en`. When end-of-packet markers arrive back to back, only the first one is passed on.

Top module: `spw_char_rx`

## Requirements
- R1: While `link_en` is low, all outputs are zero at the next clock edge and onward. The internal credit, the NULL-seen state and the escape state are all cleared, and the parity history is set to zero.
- R2: Framing is a parity bit, then a flag bit, then a payload. A flag of 0 gives 8 data bits and a flag of 1 gives 2 control bits. All payloads are sent LSB first. A bit is taken only on an edge where `rx_valid` is 1, and any number of idle cycles may come between bits.
- R3: A control code is {second bit, first bit}, with 0 = FCT, 1 = EOP, 2 = EEP and 3 = ESC. ESC followed by FCT is a NULL, which is not reported. ESC followed by a data character is a Time-code, which pulses `got_tc` and places the payload on `tc_data`.
- R4: After `link_en` rises, no report and no error is produced until a NULL has been received.
- R5: Reports appear in the cycle after the edge that accepted a character's last bit. They are single-cycle pulses, at most one per cycle, and `nchar_data` and `tc_data` hold their values until the next report of the same kind.
- R6: Parity is odd over three things: the previous character's payload bits, the current parity bit and the current flag bit. For the first character after `link_en` rises, the previous payload counts as zero. A violation sets `err_parity`.
- R7: ESC followed by ESC, EOP or EEP sets `err_escape`.
- R8: Each `fct_sent` pulse adds 8 to the credit, and the credit saturates at 56. Each N-Char received takes away 1; N-Chars are data, EOP and EEP, and dropped markers also count. An N-Char that arrives when the credit is zero sets `err_credit` and is not reported.
- R9: An EOP or EEP that follows an earlier EOP or EEP with no data character between them is dropped. FCTs and Time-codes in between do not change this.
- R10: Error flags stay set until `link_en` goes low. `err_reset_req` is the OR of the three flags. Once any flag is set, no further reports are made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_en | input | 1 | Receiver enabled (low = error reset) |
| rx_bit | input | 1 | Recovered serial bit |
| rx_valid | input | 1 | Qualifies `rx_bit` |
| fct_sent | input | 1 | Local side transmitted an FCT |
| got_tc | output | 1 | Time-code received |
| tc_data | output | 8 | Last Time-code value |
| got_fct | output | 1 | FCT received |
| got_nchar | output | 1 | Data character received |
| nchar_data | output | 8 | Last data character |
| got_eop | output | 1 | End of packet received |
| got_eep | output | 1 | Error end of packet received |
| err_parity | output | 1 | Parity error (sticky) |
| err_escape | output | 1 | Escape error (sticky) |
| err_credit | output | 1 | Credit error (sticky) |
| err_reset_req | output | 1 | Any error; asks for error reset |

## Verification
Every report and every error flag becomes visible one cycle after the clock edge that took the final bit of a character. The bench therefore checks at the falling edge that follows that edge, when the pulse is stable. A `fct_sent` pulse changes the credit at its own edge, and a low `link_en` clears the state at the next edge; the bench waits at least one full cycle before relying on either. A monitor counts the pulses at each falling edge, and the checks then compare those counts and the captured data against a model of the credit, parity and marker state kept in the bench.

// File: rtl/spw_rx_pkg.sv
package spw_rx_pkg;

    localparam int CHAR_W = 8;

    typedef enum logic [1:0] {
        CC_FCT = 2'd0,
        CC_EOP = 2'd1,
        CC_EEP = 2'd2,
        CC_ESC = 2'd3
    } ctrl_code_e;

    typedef struct packed {
        logic              done;
        logic              is_ctrl;
        logic              par_ok;
        logic [CHAR_W-1:0] payload;
    } rx_char_t;

endpackage

// File: rtl/spw_rx_framer.sv
module spw_rx_framer
    import spw_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en,
    input  logic     rx_bit,
    input  logic     rx_valid,
    output rx_char_t chr
);

    typedef struct packed {
        logic [3:0]        cnt;
        logic              par;
        logic              flag;
        logic [CHAR_W-1:0] shift;
        logic              prev_par;
    } frm_t;

    frm_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        chr = '0;
        if (!en) begin
            s_d = '0;
        end else if (rx_valid) begin
            case (s_q.cnt)
                4'd0: begin
                    s_d.par = rx_bit;
                    s_d.cnt = 4'd1;
                end
                4'd1: begin
                    s_d.flag = rx_bit;
                    s_d.cnt  = 4'd2;
                end
                default: begin
                    s_d.shift[3'(s_q.cnt - 4'd2)] = rx_bit;
                    if ((s_q.flag && s_q.cnt == 4'd3) || (!s_q.flag && s_q.cnt == 4'd9)) begin
                        chr.done     = 1'b1;
                        chr.is_ctrl  = s_q.flag;
                        chr.payload  = s_q.flag ? {6'b0, s_d.shift[1:0]} : s_d.shift;
                        chr.par_ok   = s_q.prev_par ^ s_q.par ^ s_q.flag;
                        s_d.prev_par = ^chr.payload;
                        s_d.cnt      = 4'd0;
                        s_d.shift    = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + 4'd1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/spw_rx_credit.sv
module spw_rx_credit #(
    parameter int CREDIT_W    = 6,
    parameter int CREDIT_STEP = 8,
    parameter int CREDIT_MAX  = 56
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                add,
    input  logic                take,
    output logic [CREDIT_W-1:0] credit,
    output logic                zero
);

    localparam logic [CREDIT_W:0]   STEP_W = (CREDIT_W+1)'(CREDIT_STEP);
    localparam logic [CREDIT_W:0]   MAX_WX = (CREDIT_W+1)'(CREDIT_MAX);
    localparam logic [CREDIT_W-1:0] MAX_W  = CREDIT_W'(CREDIT_MAX);

    logic [CREDIT_W-1:0] credit_q, credit_d;
    logic [CREDIT_W:0]   sum;

    always_comb begin
        sum      = {1'b0, credit_q} + STEP_W;
        credit_d = credit_q;
        if (add) credit_d = (sum > MAX_WX) ? MAX_W : sum[CREDIT_W-1:0];
        if (take && credit_d != '0) credit_d = credit_d - CREDIT_W'(1);
        if (!en) credit_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) credit_q <= '0;
        else        credit_q <= credit_d;
    end

    assign credit = credit_q;
    assign zero   = (credit_q == '0);

endmodule

// File: rtl/spw_rx_decode.sv
module spw_rx_decode
    import spw_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  rx_char_t          chr,
    input  logic              credit_zero,
    output logic              take,
    output logic              null_seen,
    output logic              got_tc,
    output logic [CHAR_W-1:0] tc_data,
    output logic              got_fct,
    output logic              got_nchar,
    output logic [CHAR_W-1:0] nchar_data,
    output logic              got_eop,
    output logic              got_eep,
    output logic              err_parity,
    output logic              err_escape,
    output logic              err_credit
);

    typedef struct packed {
        logic              null_seen;
        logic              esc_pend;
        logic              eop_last;
        logic              err_par;
        logic              err_esc;
        logic              err_cred;
        logic              got_tc;
        logic              got_fct;
        logic              got_n;
        logic              got_eop;
        logic              got_eep;
        logic [CHAR_W-1:0] tc_data;
        logic [CHAR_W-1:0] n_data;
    } dec_t;

    dec_t       q, d;
    logic       halted;
    ctrl_code_e code;

    always_comb begin
        d         = q;
        d.got_tc  = 1'b0;
        d.got_fct = 1'b0;
        d.got_n   = 1'b0;
        d.got_eop = 1'b0;
        d.got_eep = 1'b0;
        take      = 1'b0;
        halted    = q.err_par | q.err_esc | q.err_cred;
        code      = ctrl_code_e'(chr.payload[1:0]);
        if (!en) begin
            d = '0;
        end else if (chr.done && !halted) begin
            if (!chr.par_ok) begin
                if (q.null_seen) d.err_par = 1'b1;
            end else if (chr.is_ctrl) begin
                if (q.esc_pend) begin
                    d.esc_pend = 1'b0;
                    if (code == CC_FCT)   d.null_seen = 1'b1;
                    else if (q.null_seen) d.err_esc   = 1'b1;
                end else begin
                    case (code)
                        CC_ESC: d.esc_pend = 1'b1;
                        CC_FCT: d.got_fct  = q.null_seen;
                        default: begin
                            if (q.null_seen) begin
                                if (credit_zero) begin
                                    d.err_cred = 1'b1;
                                end else begin
                                    take = 1'b1;
                                    if (!q.eop_last) begin
                                        d.got_eop = (code == CC_EOP);
                                        d.got_eep = (code == CC_EEP);
                                    end
                                    d.eop_last = 1'b1;
                                end
                            end
                        end
                    endcase
                end
            end else begin
                if (q.esc_pend) begin
                    d.esc_pend = 1'b0;
                    if (q.null_seen) begin
                        d.got_tc  = 1'b1;
                        d.tc_data = chr.payload;
                    end
                end else if (q.null_seen) begin
                    if (credit_zero) begin
                        d.err_cred = 1'b1;
                    end else begin
                        take       = 1'b1;
                        d.got_n    = 1'b1;
                        d.n_data   = chr.payload;
                        d.eop_last = 1'b0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign null_seen  = q.null_seen;
    assign got_tc     = q.got_tc;
    assign tc_data    = q.tc_data;
    assign got_fct    = q.got_fct;
    assign got_nchar  = q.got_n;
    assign nchar_data = q.n_data;
    assign got_eop    = q.got_eop;
    assign got_eep    = q.got_eep;
    assign err_parity = q.err_par;
    assign err_escape = q.err_esc;
    assign err_credit = q.err_cred;

endmodule

// File: rtl/spw_char_rx.sv
module spw_char_rx
    import spw_rx_pkg::*;
#(
    parameter int CREDIT_W    = 6,
    parameter int CREDIT_STEP = 8,
    parameter int CREDIT_MAX  = 56
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_en,
    input  logic              rx_bit,
    input  logic              rx_valid,
    input  logic              fct_sent,
    output logic              got_tc,
    output logic [CHAR_W-1:0] tc_data,
    output logic              got_fct,
    output logic              got_nchar,
    output logic [CHAR_W-1:0] nchar_data,
    output logic              got_eop,
    output logic              got_eep,
    output logic              err_parity,
    output logic              err_escape,
    output logic              err_credit,
    output logic              err_reset_req
);

    rx_char_t            chr;
    logic                take;
    logic                credit_zero;
    logic [CREDIT_W-1:0] credit_val;
    logic                null_seen;

    spw_rx_framer u_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (link_en),
        .rx_bit   (rx_bit),
        .rx_valid (rx_valid),
        .chr      (chr)
    );

    spw_rx_credit #(
        .CREDIT_W    (CREDIT_W),
        .CREDIT_STEP (CREDIT_STEP),
        .CREDIT_MAX  (CREDIT_MAX)
    ) u_credit (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (link_en),
        .add    (fct_sent),
        .take   (take),
        .credit (credit_val),
        .zero   (credit_zero)
    );

    spw_rx_decode u_decode (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (link_en),
        .chr         (chr),
        .credit_zero (credit_zero),
        .take        (take),
        .null_seen   (null_seen),
        .got_tc      (got_tc),
        .tc_data     (tc_data),
        .got_fct     (got_fct),
        .got_nchar   (got_nchar),
        .nchar_data  (nchar_data),
        .got_eop     (got_eop),
        .got_eep     (got_eep),
        .err_parity  (err_parity),
        .err_escape  (err_escape),
        .err_credit  (err_credit)
    );

    assign err_reset_req = err_parity | err_escape | err_credit;

endmodule

// File: rtl/spw_char_rx_chk.sv
module spw_char_rx_chk #(
    parameter int CREDIT_W   = 6,
    parameter int CREDIT_MAX = 56
) (
    input logic                clk,
    input logic                rst_n,
    input logic                link_en,
    input logic                got_tc,
    input logic                got_fct,
    input logic                got_nchar,
    input logic                got_eop,
    input logic                got_eep,
    input logic                err_parity,
    input logic                err_escape,
    input logic                err_credit,
    input logic                err_reset_req,
    input logic [CREDIT_W-1:0] credit_val,
    input logic                null_seen
);

    logic [4:0] gots;
    logic [2:0] errs;
    assign gots = {got_tc, got_fct, got_nchar, got_eop, got_eep};
    assign errs = {err_parity, err_escape, err_credit};

    p_idle_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !link_en |=> (gots == '0 && errs == '0 && credit_val == '0 && !null_seen));

    p_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gots != '0) |-> null_seen);

    p_single_report_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gots));

    p_credit_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_credit) |-> ($past(credit_val) == '0));

    p_credit_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        credit_val <= CREDIT_W'(CREDIT_MAX));

    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((errs != '0) && link_en) |=> ((errs & $past(errs)) == $past(errs)));

    p_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_reset_req |=> (gots == '0));

endmodule

bind spw_char_rx spw_char_rx_chk #(
    .CREDIT_W   (CREDIT_W),
    .CREDIT_MAX (CREDIT_MAX)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .link_en       (link_en),
    .got_tc        (got_tc),
    .got_fct       (got_fct),
    .got_nchar     (got_nchar),
    .got_eop       (got_eop),
    .got_eep       (got_eep),
    .err_parity    (err_parity),
    .err_escape    (err_escape),
    .err_credit    (err_credit),
    .err_reset_req (err_reset_req),
    .credit_val    (credit_val),
    .null_seen     (null_seen)
);

// File: tb/sim_spw_char_rx.sv
`timescale 1ns/1ps
module sim_spw_char_rx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       link_en = 1'b0;
    logic       rx_bit = 1'b0;
    logic       rx_valid = 1'b0;
    logic       fct_sent = 1'b0;
    logic       got_tc, got_fct, got_nchar, got_eop, got_eep;
    logic [7:0] tc_data, nchar_data;
    logic       err_parity, err_escape, err_credit, err_reset_req;

    always #2 clk = ~clk;

    spw_char_rx u0 (
        .clk(clk), .rst_n(rst_n), .link_en(link_en), .rx_bit(rx_bit),
        .rx_valid(rx_valid), .fct_sent(fct_sent), .got_tc(got_tc),
        .tc_data(tc_data), .got_fct(got_fct), .got_nchar(got_nchar),
        .nchar_data(nchar_data), .got_eop(got_eop), .got_eep(got_eep),
        .err_parity(err_parity), .err_escape(err_escape),
        .err_credit(err_credit), .err_reset_req(err_reset_req)
    );

    int checks = 0;
    int errors = 0;
    int cnt_n = 0, cnt_tc = 0, cnt_fct = 0, cnt_eop = 0, cnt_eep = 0;
    logic [7:0] last_n = 8'h00, last_tc = 8'h00;
    logic prev_p = 1'b0;
    int   credit_m = 0;
    bit   done = 1'b0;

    localparam logic [1:0] FCT = 2'd0, EOP = 2'd1, EEP = 2'd2, ESC = 2'd3;

    always @(negedge clk) begin
        if (got_nchar) begin cnt_n++; last_n = nchar_data; end
        if (got_tc)    begin cnt_tc++; last_tc = tc_data; end
        if (got_fct)   cnt_fct++;
        if (got_eop)   cnt_eop++;
        if (got_eep)   cnt_eep++;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input int gap);
        repeat (gap) @(negedge clk);
        @(negedge clk);
        rx_bit   = b;
        rx_valid = 1'b1;
        @(posedge clk);
        #1 rx_valid = 1'b0;
    endtask

    task automatic send_char(input logic flag, input logic [7:0] pl,
                             input logic bad, input int gap);
        logic p;
        p = ~(prev_p ^ flag) ^ bad;
        send_bit(p, gap);
        send_bit(flag, gap);
        for (int i = 0; i < (flag ? 2 : 8); i++) send_bit(pl[i], gap);
        prev_p = flag ? ^pl[1:0] : ^pl;
        @(negedge clk);
        #1;
    endtask

    task automatic send_ctrl(input logic [1:0] c);
        send_char(1'b1, {6'b0, c}, 1'b0, 0);
    endtask

    task automatic send_data(input logic [7:0] v);
        send_char(1'b0, v, 1'b0, 0);
    endtask

    task automatic send_null();
        send_ctrl(ESC);
        send_ctrl(FCT);
    endtask

    task automatic give_fct();
        @(negedge clk);
        fct_sent = 1'b1;
        @(posedge clk);
        #1 fct_sent = 1'b0;
        credit_m = (credit_m + 8 > 56) ? 56 : credit_m + 8;
    endtask

    task automatic link_cycle();
        @(negedge clk);
        link_en = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        chk("R1 errors cleared", int'({err_parity, err_escape, err_credit}), 0);
        link_en  = 1'b1;
        prev_p   = 1'b0;
        credit_m = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        int n0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset outputs", int'({got_tc, got_fct, got_nchar, got_eop, got_eep,
                                      err_parity, err_escape, err_credit, err_reset_req}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        link_en = 1'b1;

        // R4: nothing reported and no error before the first NULL
        give_fct();
        send_ctrl(ESC); send_ctrl(ESC);
        send_ctrl(FCT); send_data(8'h55); send_ctrl(EOP);
        chk("R4 no reports before NULL", cnt_n + cnt_fct + cnt_eop + cnt_tc, 0);
        chk("R4 no error before NULL", int'(err_reset_req), 0);

        // R3: NULL opens the receiver, FCT reported
        send_null();
        send_ctrl(FCT);
        chk("R3 FCT reported", cnt_fct, 1);
        chk("R3 NULL not reported", cnt_n + cnt_tc, 0);

        // R5: latency and pulse width
        send_data(8'hA5);
        credit_m--;
        chk("R5 got_nchar in cycle after last bit", int'(got_nchar), 1);
        chk("R5 nchar_data", int'(nchar_data), 8'hA5);
        @(negedge clk); #1;
        chk("R5 single-cycle pulse", int'(got_nchar), 0);
        chk("R5 data held", int'(nchar_data), 8'hA5);

        // R2: sweep all data values, idle gaps between bits
        for (int v = 0; v < 256; v++) begin
            n0 = cnt_n;
            if (credit_m == 0) give_fct();
            send_char(1'b0, 8'(v), 1'b0, v % 3);
            credit_m--;
            chk("R2 data count", cnt_n, n0 + 1);
            chk("R2 data value", int'(last_n), v);
        end

        // R3: Time-codes
        for (int k = 0; k < 6; k++) begin
            logic [7:0] tv;
            tv = 8'(k * 51 + 1);
            n0 = cnt_n;
            send_ctrl(ESC);
            send_data(tv);
            chk("R3 time-code value", int'(last_tc), int'(tv));
            chk("R3 time-code is not an N-Char", cnt_n, n0);
        end
        chk("R3 time-code count", cnt_tc, 6);

        // R9: end-marker filtering
        while (credit_m < 6) give_fct();
        send_ctrl(EOP); credit_m--;
        chk("R9 first EOP", cnt_eop, 1);
        send_ctrl(EEP); credit_m--;
        send_ctrl(FCT);
        send_ctrl(EOP); credit_m--;
        send_ctrl(ESC); send_data(8'h11);
        send_ctrl(EEP); credit_m--;
        chk("R9 repeated markers dropped", cnt_eop * 10 + cnt_eep, 10);
        send_data(8'h22); credit_m--;
        send_ctrl(EEP); credit_m--;
        chk("R9 EEP after data", cnt_eep, 1);
        chk("R9 no error", int'(err_reset_req), 0);

        // R8: drain, saturate at 56, then overrun
        while (credit_m > 0) begin send_data(8'h33); credit_m--; end
        repeat (8) give_fct();
        n0 = cnt_n;
        for (int i = 0; i < 56; i++) send_data(8'(i));
        chk("R8 saturated credit allows 56", cnt_n, n0 + 56);
        chk("R8 no error within credit", int'(err_credit), 0);
        send_data(8'h77);
        chk("R8 credit error", int'(err_credit), 1);
        chk("R8 char not reported", cnt_n, n0 + 56);
        chk("R10 reset request", int'(err_reset_req), 1);
        give_fct();
        send_data(8'h78); send_ctrl(FCT);
        chk("R10 halted after error", cnt_n, n0 + 56);
        chk("R10 error sticky", int'(err_credit), 1);

        // R1: link cycle clears credit and NULL state
        link_cycle();
        send_data(8'h01);
        chk("R1 gated again after re-enable", cnt_n, n0 + 56);
        send_null();
        send_data(8'h02);
        chk("R1 credit cleared", int'(err_credit), 1);

        // R6: parity errors on data and on control
        link_cycle();
        send_null();
        give_fct();
        n0 = cnt_n;
        send_char(1'b0, 8'h5A, 1'b1, 0);
        chk("R6 data parity error", int'(err_parity), 1);
        chk("R6 bad char not reported", cnt_n, n0);
        link_cycle();
        send_null();
        give_fct();
        send_data(8'h01);
        send_char(1'b1, {6'b0, EOP}, 1'b1, 0);
        chk("R6 control parity error", int'(err_parity), 1);
        chk("R6 only parity flag", int'({err_escape, err_credit}), 0);

        // R7: escape errors
        link_cycle();
        send_null(); send_ctrl(ESC); send_ctrl(EOP);
        chk("R7 ESC EOP", int'(err_escape), 1);
        link_cycle();
        send_null(); send_ctrl(ESC); send_ctrl(ESC);
        chk("R7 ESC ESC", int'(err_escape), 1);
        link_cycle();
        send_null(); send_ctrl(ESC); send_ctrl(EEP);
        chk("R7 ESC EEP", int'(err_escape), 1);
        chk("R10 reset request on escape", int'(err_reset_req), 1);

        finish_run();
    end

endmodule